// File: doc/BRIEF.md
# Lane-Preserving Warp Regrouping Pool

After a branch commits, a warp splits into a group of threads that took the branch and a group that did not. This block collects such groups from many static warps and packs threads that sit at the same program counter into shared dynamic warps. A thread never changes lane, so its register bank stays the same. The pool holds a fixed number of warp slots. For each slot it keeps the PC, a lane-occupancy vector, a thread ID per lane, and an "open" flag. The open flag marks the slot that the PC lookup currently points to for that PC.

A commit is accepted into two internal update registers, one for the taken group and one for the not-taken group. The registers are then served one per cycle, taken first. A served group is merged into the open slot at the same PC when no lane collides. Otherwise it gets a fresh slot, which becomes the open slot for that PC. A scheduler pulls formed warps out in allocation order with a one-cycle issue strobe. While a group cannot be placed because every slot is in use, the block withdraws its commit-ready signal.

Top module: `dwf_pool`

## Requirements
- R1: After reset, `upd_ready` is 1, `iss_valid` is 0 and the pool is empty.
- R2: A group whose PC matches the open slot at that PC, and whose lane mask (bit i = lane i) does not intersect that slot's occupancy, is merged into that slot. Each thread ID lands in its home lane (field `[i*TID_W +: TID_W]`), and the occupancy becomes the OR of both masks.
- R3: A group whose PC matches the open slot but shares at least one lane with it is placed in a new slot. From then on, lookups for that PC reach only the new slot, even if the older slot still has free lanes.
- R4: A group whose PC has no open slot is placed in a new slot whose occupancy equals the group mask.
- R5: The taken group of a commit is placed before the not-taken group. When both groups carry the same PC and disjoint masks, they end up in one slot.
- R6: When `iss_en` is sampled high at an edge and the pool is non-empty, the slot allocated earliest is removed. On the next cycle `iss_valid` is 1 for one cycle, with that slot's PC, occupancy mask, and thread IDs. Thread-ID fields of unoccupied lanes read as zero.
- R7: While a served group needs a new slot and every slot is in use, `upd_ready` stays 0 and the group is held. It is placed in the cycle after an issue frees a slot.
- R8: A group with an all-zero mask creates no slot and is not issued.
- R9: `iss_en` on an empty pool produces no `iss_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_valid | input | 1 | Commit presented; taken when `upd_ready` is 1 |
| cm_tk_pc | input | PC_W | PC of the taken group |
| cm_tk_mask | input | LANES | Lanes of the taken group |
| cm_tk_tids | input | LANES*TID_W | Thread IDs of the taken group, one field per lane |
| cm_nt_pc | input | PC_W | PC of the not-taken group |
| cm_nt_mask | input | LANES | Lanes of the not-taken group |
| cm_nt_tids | input | LANES*TID_W | Thread IDs of the not-taken group |
| upd_ready | output | 1 | Both update registers are empty |
| iss_en | input | 1 | Scheduler asks for the oldest formed warp |
| iss_valid | output | 1 | Issued warp present this cycle |
| iss_pc | output | PC_W | PC of the issued warp |
| iss_mask | output | LANES | Occupied lanes of the issued warp |
| iss_tids | output | LANES*TID_W | Thread IDs of the issued warp, zero in unoccupied lanes |

## Verification
The bench builds the block with four lanes, a four-slot pool, 6-bit thread IDs and 8-bit PCs. Four lanes are enough to set up a full merge from two partial masks, a lane collision, and a later merge that has to bypass an older slot that still has a free lane. Four slots are few enough that two commits fill the pool, so a held request, and the taken-before-not-taken order that it makes visible in the issue sequence, can be reached in a short run.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2,
    ACT_STALL = 2'd3
  } act_e;
endpackage

// File: rtl/dwf_lut.sv
module dwf_lut #(
  parameter int LANES = 4,
  parameter int PC_W  = 8,
  parameter int POOL  = 4,
  localparam int IDX_W = (POOL > 1) ? $clog2(POOL) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [POOL-1:0]             ent_valid,
  input  logic [POOL-1:0]             ent_open,
  input  logic [POOL-1:0][PC_W-1:0]   ent_pc,
  input  logic [POOL-1:0][LANES-1:0]  ent_occ,
  input  logic                        excl_en,
  input  logic [IDX_W-1:0]            excl_idx,
  input  logic [PC_W-1:0]             q_pc,
  input  logic [LANES-1:0]            q_mask,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx,
  output logic                        conflict
);
  logic [POOL-1:0] match;

  // one comparator per slot; a slot leaving through issue this cycle is skipped
  for (genvar g = 0; g < POOL; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && ent_open[g] && (ent_pc[g] == q_pc) &&
                      !(excl_en && (excl_idx == IDX_W'(g)));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit      = |match;
  assign conflict = hit && ((ent_occ[hit_idx] & q_mask) != '0);

  // R3: the lookup never sees two open slots for one PC
  p_single_open_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(match))
    else $error("two open slots match one PC");
endmodule

// File: rtl/dwf_alloc.sv
module dwf_alloc #(
  parameter int POOL = 4,
  localparam int IDX_W = (POOL > 1) ? $clog2(POOL) : 1,
  localparam int CNT_W = $clog2(POOL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POOL-1:0]  ent_valid,
  input  logic             push,
  input  logic             pop,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx,
  output logic [IDX_W-1:0] head_idx,
  output logic             nonempty
);
  logic [IDX_W-1:0] order [POOL];
  logic [IDX_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    free_idx = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign free_any = ~&ent_valid;
  assign head_idx = order[rp];
  assign nonempty = (cnt != '0);

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(POOL - 1)) ? '0 : p + 1'b1;
  endfunction

  // age order of slots: written at allocation, read at issue
  always_ff @(posedge clk) begin
    if (push) order[wp] <= free_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // R6: the age queue never holds more slots than exist
  p_age_bound_r6: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(POOL))
    else $error("age queue overflow");
  // R7: an allocation only happens when a slot is free
  p_push_free_r7: assert property (@(posedge clk) disable iff (rst) push |-> free_any)
    else $error("allocation into a full pool");
endmodule

// File: rtl/dwf_pool.sv
module dwf_pool
  import dwf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TID_W = 6,
  parameter int PC_W  = 8,
  parameter int POOL  = 4,
  localparam int IDX_W = (POOL > 1) ? $clog2(POOL) : 1,
  localparam int TW    = LANES * TID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cm_valid,
  input  logic [PC_W-1:0]  cm_tk_pc,
  input  logic [LANES-1:0] cm_tk_mask,
  input  logic [TW-1:0]    cm_tk_tids,
  input  logic [PC_W-1:0]  cm_nt_pc,
  input  logic [LANES-1:0] cm_nt_mask,
  input  logic [TW-1:0]    cm_nt_tids,
  output logic             upd_ready,
  input  logic             iss_en,
  output logic             iss_valid,
  output logic [PC_W-1:0]  iss_pc,
  output logic [LANES-1:0] iss_mask,
  output logic [TW-1:0]    iss_tids
);
  typedef struct packed {
    logic             v;
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] m;
    logic [TW-1:0]    t;
  } grp_t;

  grp_t tk_q, nt_q, cur;

  logic [POOL-1:0]             ent_valid, ent_open;
  logic [POOL-1:0][PC_W-1:0]   ent_pc;
  logic [POOL-1:0][LANES-1:0]  ent_occ;
  logic [LANES-1:0][TID_W-1:0] tid_mem [POOL];

  logic             hit, conflict, free_any, q_nonempty, issue_go;
  logic [IDX_W-1:0] hit_idx, free_idx, head_idx, wr_idx;
  logic [TW-1:0]    iss_tids_d;
  act_e             act;

  assign upd_ready = !tk_q.v && !nt_q.v;
  assign cur       = tk_q.v ? tk_q : nt_q;
  assign issue_go  = iss_en && q_nonempty;

  dwf_lut #(.LANES(LANES), .PC_W(PC_W), .POOL(POOL)) u_lut (
    .clk(clk), .rst(rst),
    .ent_valid(ent_valid), .ent_open(ent_open), .ent_pc(ent_pc), .ent_occ(ent_occ),
    .excl_en(issue_go), .excl_idx(head_idx),
    .q_pc(cur.pc), .q_mask(cur.m),
    .hit(hit), .hit_idx(hit_idx), .conflict(conflict)
  );

  dwf_alloc #(.POOL(POOL)) u_alloc (
    .clk(clk), .rst(rst), .ent_valid(ent_valid),
    .push(act == ACT_ALLOC), .pop(issue_go),
    .free_any(free_any), .free_idx(free_idx),
    .head_idx(head_idx), .nonempty(q_nonempty)
  );

  always_comb begin
    if (!cur.v)                act = ACT_NONE;
    else if (hit && !conflict) act = ACT_MERGE;
    else if (free_any)         act = ACT_ALLOC;
    else                       act = ACT_STALL;
  end

  assign wr_idx = (act == ACT_MERGE) ? hit_idx : free_idx;

  // thread-ID storage: per-lane write enables, no reset
  always_ff @(posedge clk) begin
    if (act == ACT_MERGE || act == ACT_ALLOC) begin
      for (int l = 0; l < LANES; l++) begin
        if (cur.m[l]) tid_mem[wr_idx][l] <= cur.t[l*TID_W +: TID_W];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      iss_tids_d[l*TID_W +: TID_W] = ent_occ[head_idx][l] ? tid_mem[head_idx][l] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ent_open  <= '0;
      ent_pc    <= '0;
      ent_occ   <= '0;
      tk_q      <= '0;
      nt_q      <= '0;
      iss_valid <= 1'b0;
      iss_pc    <= '0;
      iss_mask  <= '0;
      iss_tids  <= '0;
    end else begin
      if (issue_go) begin
        ent_valid[head_idx] <= 1'b0;
        ent_open[head_idx]  <= 1'b0;
      end
      if (act == ACT_MERGE) begin
        ent_occ[hit_idx] <= ent_occ[hit_idx] | cur.m;
      end
      if (act == ACT_ALLOC) begin
        ent_valid[free_idx] <= 1'b1;
        ent_open[free_idx]  <= 1'b1;
        ent_pc[free_idx]    <= cur.pc;
        ent_occ[free_idx]   <= cur.m;
        if (hit) ent_open[hit_idx] <= 1'b0;
      end
      if (act == ACT_MERGE || act == ACT_ALLOC) begin
        if (tk_q.v) tk_q.v <= 1'b0;
        else        nt_q.v <= 1'b0;
      end
      if (cm_valid && upd_ready) begin
        tk_q <= '{v: |cm_tk_mask, pc: cm_tk_pc, m: cm_tk_mask, t: cm_tk_tids};
        nt_q <= '{v: |cm_nt_mask, pc: cm_nt_pc, m: cm_nt_mask, t: cm_nt_tids};
      end
      iss_valid <= issue_go;
      if (issue_go) begin
        iss_pc   <= ent_pc[head_idx];
        iss_mask <= ent_occ[head_idx];
        iss_tids <= iss_tids_d;
      end
    end
  end

  // R2: a merge leaves the slot holding both lane sets
  p_merge_union_r2: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_MERGE) |=> (ent_occ[$past(hit_idx)] == ($past(ent_occ[hit_idx]) | $past(cur.m))))
    else $error("merge lost lanes");
  // R6: the age queue agrees with the slot valid bits
  p_age_matches_r6: assert property (@(posedge clk) disable iff (rst) q_nonempty == (|ent_valid))
    else $error("age queue out of step with pool");
  // R7: a held group stays held until an issue frees a slot
  p_hold_full_r7: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STALL && !issue_go) |=> (act == ACT_STALL && !upd_ready))
    else $error("stalled group released without a free slot");
  // R9: nothing comes out of an empty pool
  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (iss_en && !(|ent_valid)) |=> !iss_valid)
    else $error("issue from empty pool");
endmodule

// File: tb/sim_dwf_pool.sv
module sim_dwf_pool;
  localparam int LANES = 4, TID_W = 6, PC_W = 8, POOL = 4;
  localparam int TW = LANES * TID_W;

  logic clk = 1'b0, rst = 1'b1;
  logic cm_valid = 1'b0, iss_en = 1'b0;
  logic [PC_W-1:0] cm_tk_pc = '0, cm_nt_pc = '0;
  logic [LANES-1:0] cm_tk_mask = '0, cm_nt_mask = '0;
  logic [TW-1:0] cm_tk_tids = '0, cm_nt_tids = '0;
  logic upd_ready, iss_valid;
  logic [PC_W-1:0] iss_pc;
  logic [LANES-1:0] iss_mask;
  logic [TW-1:0] iss_tids;

  int checks = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] m;
    logic [TW-1:0]    t;
  } item_t;
  item_t expq[$];

  always #4 clk = ~clk;

  dwf_pool #(.LANES(LANES), .TID_W(TID_W), .PC_W(PC_W), .POOL(POOL)) u0 (
    .clk(clk), .rst(rst), .cm_valid(cm_valid),
    .cm_tk_pc(cm_tk_pc), .cm_tk_mask(cm_tk_mask), .cm_tk_tids(cm_tk_tids),
    .cm_nt_pc(cm_nt_pc), .cm_nt_mask(cm_nt_mask), .cm_nt_tids(cm_nt_tids),
    .upd_ready(upd_ready), .iss_en(iss_en), .iss_valid(iss_valid),
    .iss_pc(iss_pc), .iss_mask(iss_mask), .iss_tids(iss_tids)
  );

  function automatic logic [TW-1:0] ids(input int base);
    logic [TW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*TID_W +: TID_W] = TID_W'(base + l);
    return r;
  endfunction

  function automatic logic [TW-1:0] pick(input logic [TW-1:0] t, input logic [LANES-1:0] m);
    logic [TW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*TID_W +: TID_W] = m[l] ? t[l*TID_W +: TID_W] : '0;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    while (!upd_ready) @(negedge clk);
  endtask

  task automatic commit(input logic [PC_W-1:0] tp, input logic [LANES-1:0] tm, input int tb,
                        input logic [PC_W-1:0] np, input logic [LANES-1:0] nm, input int nb);
    while (!upd_ready) @(negedge clk);
    cm_valid = 1'b1;
    cm_tk_pc = tp; cm_tk_mask = tm; cm_tk_tids = ids(tb);
    cm_nt_pc = np; cm_nt_mask = nm; cm_nt_tids = ids(nb);
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic issue_expect(input string req, input logic [PC_W-1:0] pc,
                              input logic [LANES-1:0] m, input logic [TW-1:0] t);
    item_t it;
    it.pc = pc; it.m = m; it.t = t;
    expq.push_back(it);
    iss_en = 1'b1;
    @(negedge clk);
    iss_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic issue_none();
    iss_en = 1'b1;
    @(negedge clk);
    iss_en = 1'b0;
    @(negedge clk);
  endtask

  // monitor: every issued warp must match the oldest expected item (R6)
  always @(negedge clk) begin
    if (!rst && iss_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9/R8 unexpected issue", longint'(iss_pc), 0);
      end else begin
        item_t e;
        e = expq.pop_front();
        check(iss_pc == e.pc && iss_mask == e.m && iss_tids == e.t, "R6 issued warp",
              longint'({iss_pc, iss_mask, iss_tids}), longint'({e.pc, e.m, e.t}));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(upd_ready == 1'b1, "R1 ready after reset", longint'(upd_ready), 1);
    check(iss_valid == 1'b0, "R1 no issue after reset", longint'(iss_valid), 0);

    // R4 new slots for A and B; R2 merge of B into full warp; R3 conflict at A
    commit(8'h0A, 4'b0110, 8, 8'h0B, 4'b1001, 16);
    commit(8'h0B, 4'b0110, 24, 8'h0A, 4'b0011, 32);
    // R3: lane 3 free in the older A slot, but only the newer A slot is open
    commit(8'h0A, 4'b1000, 40, 8'h00, 4'b0000, 0);
    settle();
    issue_expect("R4", 8'h0A, 4'b0110, pick(ids(8), 4'b0110));
    issue_expect("R2", 8'h0B, 4'b1111, pick(ids(16), 4'b1001) | pick(ids(24), 4'b0110));
    issue_expect("R3", 8'h0A, 4'b1011, pick(ids(32), 4'b0011) | pick(ids(40), 4'b1000));
    check(expq.size() == 0, "R6 all three issued", longint'(expq.size()), 0);

    // R5: same-PC pair from one commit lands in one slot
    commit(8'h0D, 4'b0011, 48, 8'h0D, 4'b1100, 52);
    settle();
    issue_expect("R5", 8'h0D, 4'b1111, pick(ids(48), 4'b0011) | pick(ids(52), 4'b1100));
    // R9: empty pool
    issue_none();
    check(expq.size() == 0 && !iss_valid, "R9 empty issue", longint'(iss_valid), 0);

    // R7: fill the pool, then hold a commit
    commit(8'h10, 4'b0001, 0, 8'h11, 4'b0010, 4);
    commit(8'h12, 4'b0100, 8, 8'h13, 4'b1000, 12);
    settle();
    commit(8'h14, 4'b0001, 20, 8'h15, 4'b0010, 28);
    repeat (3) @(negedge clk);
    check(upd_ready == 1'b0, "R7 held while full", longint'(upd_ready), 0);
    issue_expect("R7", 8'h10, 4'b0001, pick(ids(0), 4'b0001));
    check(upd_ready == 1'b0, "R7 second group still held", longint'(upd_ready), 0);
    issue_expect("R7", 8'h11, 4'b0010, pick(ids(4), 4'b0010));
    settle();
    check(upd_ready == 1'b1, "R7 released after issue", longint'(upd_ready), 1);
    issue_expect("R6", 8'h12, 4'b0100, pick(ids(8), 4'b0100));
    issue_expect("R6", 8'h13, 4'b1000, pick(ids(12), 4'b1000));
    // R5: the taken group of the held commit was placed first
    issue_expect("R5", 8'h14, 4'b0001, pick(ids(20), 4'b0001));
    issue_expect("R5", 8'h15, 4'b0010, pick(ids(28), 4'b0010));

    // R8: empty taken group creates nothing
    commit(8'h20, 4'b0000, 0, 8'h21, 4'b0100, 36);
    settle();
    issue_expect("R8", 8'h21, 4'b0100, pick(ids(36), 4'b0100));
    issue_none();
    check(expq.size() == 0, "R8 single warp issued", longint'(expq.size()), 0);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule